// File: doc/BRIEF.md
# Cubic B-Spline Fractional Resampler (3:2)

This block converts a stream of signed samples to a lower rate. For every three input samples it produces two output samples. Each output is a cubic B-spline interpolation at a fractional position between two neighbouring inputs. The interpolation uses a four-sample window of the two samples before the position and the two after it. Four fixed sub-filters turn the window into polynomial coefficients, and a Horner pipeline then evaluates that polynomial in the fractional offset d.

A phase accumulator decides which input arrivals yield an output and which offset applies. It advances by one and a half input samples per output, so d takes only the values 0 and one half. The input is a plain data-plus-valid stream that may have idle cycles. The output is also a data-plus-valid stream. The output word carries four more bits than the input word, all of them fractional.

Top module: `bspline_resampler`

## Requirements
- R1: After reset, no output is produced until four input samples have been accepted. The fourth accepted sample can produce the first output.
- R2: With input samples indexed from 0 since reset, output k is taken at position t = 1 + 1.5·k. With n = floor(t), that output is emitted when sample n+2 is accepted. This gives exactly two outputs per three accepted inputs.
- R3: Write a = x(n−1), b = x(n), c = x(n+1), e = x(n+2). The output value is 16·y, where y = K0 + K1·d + K2·d² + K3·d³, and:
  - K0 = (c + 4b + a)/6
  - K1 = (c − a)/2
  - K2 = (c − 2b + a)/2
  - K3 = (e − 3c + 3b − a)/6
  The output is a 20-bit two's-complement word with 4 fractional bits, within 1 LSB of 16·y.
- R4: The offset d is an unsigned 16-bit fraction. Successive outputs alternate d = 0 (code 0) and d = 0.5 (code 0x8000), starting with 0 after reset.
- R5: An output is valid exactly 4 clock cycles after the rising edge that accepted the sample triggering it. Output valid is a single-cycle strobe.
- R6: A constant input c yields exactly 16·c, including at the extreme input values +32767 and −32768.
- R7: A linearly rising or falling input is reproduced exactly. The output is 16 times the straight-line value at position t.
- R8: Idle input cycles (valid low) neither move the window nor advance the phase, nor cause outputs. Results match a gap-free stream of the same samples, apart from timing.
- R9: Reset at any time cancels outputs in flight and restarts both the window filling and the phase sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample is present this cycle |
| inData | input | 16 | Signed input sample |
| outValid | output | 1 | Output sample strobe |
| outData | output | 20 | Signed output sample with 4 fractional bits |

## Verification
The bench builds the block with its default parameters: 16-bit input, 20-bit output, a 16-bit phase fraction and a 3/2 step. With these values, full-scale inputs drive the widest coefficient magnitudes, and both offset codes occur on every pair of outputs. Flat signals at both extremes and straight ramps give exact expected words. Random full-scale samples with random idle gaps exercise the rounding margin and the skipping of idle cycles. A reset in the middle of a burst shows that outputs in flight are discarded and that the phase sequence restarts.

// File: rtl/resamp_pkg.sv
package resamp_pkg;
  typedef struct packed {
    logic shift;  // a new sample enters the window this cycle
    logic fire;   // window now holds the four samples for one output
  } resamp_ctl_t;
endpackage

// File: rtl/resamp_ctrl.sv
module resamp_ctrl
  import resamp_pkg::*;
#(
  parameter int FRAC_W   = 16,
  parameter int STEP_NUM = 3,
  parameter int STEP_DEN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output resamp_ctl_t       ctl,
  output logic [FRAC_W-1:0] dOut
);
  localparam int ACC_W = FRAC_W + 3;
  localparam logic [ACC_W-1:0] ONE    = ACC_W'(1) << FRAC_W;
  localparam logic [ACC_W-1:0] STEP_Q = ACC_W'((STEP_NUM << FRAC_W) / STEP_DEN);

  logic [2:0]        fillCnt;
  logic [ACC_W-1:0]  phaseAcc;
  logic              fireQ;
  logic [FRAC_W-1:0] dQ;
  logic              windowFull;

  // true when the incoming sample completes (or keeps) a full window
  assign windowFull = (fillCnt >= 3'd3);

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt  <= '0;
      phaseAcc <= '0;
      fireQ    <= 1'b0;
      dQ       <= '0;
    end else begin
      fireQ <= 1'b0;
      if (inValid) begin
        if (fillCnt != 3'd4) fillCnt <= fillCnt + 3'd1;
        if (windowFull) begin
          if (phaseAcc < ONE) begin
            fireQ    <= 1'b1;
            dQ       <= phaseAcc[FRAC_W-1:0];
            phaseAcc <= phaseAcc + STEP_Q - ONE;
          end else begin
            phaseAcc <= phaseAcc - ONE;
          end
        end
      end
    end
  end

  assign ctl.shift = inValid;
  assign ctl.fire  = fireQ;
  assign dOut      = dQ;
endmodule

// File: rtl/resamp_datapath.sv
module resamp_datapath
  import resamp_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int OUT_W  = 20,
  parameter int FRAC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  resamp_ctl_t             ctl,
  input  logic [FRAC_W-1:0]       dIn,
  input  logic signed [IN_W-1:0]  inData,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outData
);
  localparam int CW       = IN_W + 4;             // coefficients scaled by 6
  localparam int HW       = CW + FRAC_W + 4;      // Horner partials, FRAC_W fraction bits
  localparam int MW       = HW + FRAC_W + 1;      // product of partial and offset
  localparam int OUT_FRAC = OUT_W - IN_W;
  localparam int RK       = 24;                   // precision of the 1/6 constant
  localparam int PW       = HW + RK + 1;
  localparam int SH       = FRAC_W + RK - OUT_FRAC;
  localparam longint RECIP = ((64'sd1 <<< RK) + 64'sd3) / 64'sd6;
  localparam logic signed [PW-1:0] RECIP_S = PW'(RECIP);
  localparam logic signed [PW-1:0] ROUND_S = PW'(1) <<< (SH - 1);

  logic signed [IN_W-1:0] win [4];  // win[0] oldest x(n-1) ... win[3] newest x(n+2)

  always_ff @(posedge clk) begin
    if (rst) win[3] <= '0;
    else if (ctl.shift) win[3] <= inData;
  end

  for (genvar i = 0; i < 3; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) win[i] <= '0;
      else if (ctl.shift) win[i] <= win[i+1];
    end
  end

  function automatic logic signed [CW-1:0] ext(input logic signed [IN_W-1:0] v);
    return {{(CW-IN_W){v[IN_W-1]}}, v};
  endfunction

  function automatic logic signed [HW-1:0] toH(input logic signed [CW-1:0] v);
    logic signed [HW-1:0] t;
    t = {{(HW-CW){v[CW-1]}}, v};
    return t <<< FRAC_W;
  endfunction

  function automatic logic signed [HW-1:0] mulFrac(input logic signed [HW-1:0] h,
                                                   input logic [FRAC_W-1:0] d);
    logic signed [MW-1:0] p;
    p = MW'(h) * MW'($signed({1'b0, d}));
    return $signed(p[HW+FRAC_W-1:FRAC_W]);
  endfunction

  // sub-filters, all scaled by 6 to keep integer taps
  logic signed [CW-1:0] xa, xb, xc, xe, diffAc, curv, slopeB;
  logic signed [CW-1:0] k0, k1, k2, k3;
  always_comb begin
    xa     = ext(win[0]);
    xb     = ext(win[1]);
    xc     = ext(win[2]);
    xe     = ext(win[3]);
    diffAc = xc - xa;
    curv   = xc - (xb <<< 1) + xa;
    slopeB = xb - xc;
    k0     = xc + (xb <<< 2) + xa;
    k1     = diffAc + (diffAc <<< 1);
    k2     = curv + (curv <<< 1);
    k3     = xe - xa + slopeB + (slopeB <<< 1);
  end

  // stage 1: coefficient registers
  logic signed [CW-1:0] s1k0, s1k1, s1k2, s1k3;
  logic [FRAC_W-1:0]    s1d, s2d, s3d;
  logic signed [CW-1:0] s2k0, s2k1, s3k0;
  logic signed [HW-1:0] s2h, s3h, h3;
  logic signed [PW-1:0] scaled;
  logic                 v1, v2, v3;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1       <= 1'b0;
      v2       <= 1'b0;
      v3       <= 1'b0;
      outValid <= 1'b0;
    end else begin
      v1       <= ctl.fire;
      v2       <= v1;
      v3       <= v2;
      outValid <= v3;
    end
  end

  always_ff @(posedge clk) begin
    s1k0 <= k0;
    s1k1 <= k1;
    s1k2 <= k2;
    s1k3 <= k3;
    s1d  <= dIn;
    // stage 2: K3*d + K2
    s2h  <= mulFrac(toH(s1k3), s1d) + toH(s1k2);
    s2k0 <= s1k0;
    s2k1 <= s1k1;
    s2d  <= s1d;
    // stage 3: (.)*d + K1
    s3h  <= mulFrac(s2h, s2d) + toH(s2k1);
    s3k0 <= s2k0;
    s3d  <= s2d;
  end

  // stage 4: (.)*d + K0, then divide by 6 and round into the output format
  assign h3     = mulFrac(s3h, s3d) + toH(s3k0);
  assign scaled = PW'(h3) * RECIP_S + ROUND_S;

  always_ff @(posedge clk) begin
    outData <= $signed(scaled[SH+OUT_W-1:SH]);
  end
endmodule

// File: rtl/bspline_resampler.sv
module bspline_resampler
  import resamp_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int OUT_W    = 20,
  parameter int FRAC_W   = 16,
  parameter int STEP_NUM = 3,
  parameter int STEP_DEN = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic signed [IN_W-1:0]  inData,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outData
);
  resamp_ctl_t       ctl;
  logic [FRAC_W-1:0] dCur;

  resamp_ctrl #(
    .FRAC_W  (FRAC_W),
    .STEP_NUM(STEP_NUM),
    .STEP_DEN(STEP_DEN)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .inValid(inValid),
    .ctl    (ctl),
    .dOut   (dCur)
  );

  resamp_datapath #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W),
    .FRAC_W(FRAC_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .dIn     (dCur),
    .inData  (inData),
    .outValid(outValid),
    .outData (outData)
  );
endmodule

// File: rtl/resamp_checks.sv
module resamp_checks #(
  parameter int FRAC_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              outValid,
  input logic              fire,
  input logic [FRAC_W-1:0] dVal
);
  localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);

  logic [2:0]        acceptCnt;
  logic              haveLast;
  logic [FRAC_W-1:0] lastD;

  always_ff @(posedge clk) begin
    if (rst) begin
      acceptCnt <= '0;
      haveLast  <= 1'b0;
      lastD     <= '0;
    end else begin
      if (inValid && acceptCnt != 3'd7) acceptCnt <= acceptCnt + 3'd1;
      if (fire) begin
        haveLast <= 1'b1;
        lastD    <= dVal;
      end
    end
  end

  // R1: nothing leaves before four samples came in
  a_r1_no_early_output: assert property (@(posedge clk) disable iff (rst)
    outValid |-> acceptCnt >= 3'd4);

  // R8: an output is only launched by an accepted sample
  a_r8_fire_needs_input: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(inValid));

  // R4: offsets stay on the half-sample grid
  a_r4_half_grid: assert property (@(posedge clk) disable iff (rst)
    fire |-> (dVal == '0 || dVal == HALF));

  // R4: successive offsets alternate
  a_r4_alternates: assert property (@(posedge clk) disable iff (rst)
    (fire && haveLast) |-> dVal != lastD);

  // R5: fixed pipeline depth
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    fire |-> ##4 outValid);
endmodule

bind bspline_resampler resamp_checks #(.FRAC_W(FRAC_W)) u_checks (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .outValid(outValid),
  .fire    (ctl.fire),
  .dVal    (dCur)
);

// File: tb/bspline_resampler_bench.sv
module bspline_resampler_bench;
  localparam int IN_W  = 16;
  localparam int OUT_W = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [IN_W-1:0]  inData = '0;
  logic                    outValid;
  logic signed [OUT_W-1:0] outData;

  always #5 clk = ~clk;

  bspline_resampler u_bspline_resampler (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int seen   = 0;
  bit done   = 0;

  int    hist [0:4095];
  int    idx    = 0;
  int    nextT2 = 2;  // output position in half-sample units
  real   expQ [$];
  int    cycQ [$];
  real   tolQ [$];
  string tagQ [$];
  string curTag = "R3";
  real   curTol = 1.0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  function automatic real interp(input int n, input real d);
    real a, b, c, e, k0, k1, k2, k3;
    a = real'(hist[n-1]); b = real'(hist[n]); c = real'(hist[n+1]); e = real'(hist[n+2]);
    k0 = (c + 4.0*b + a) / 6.0;
    k1 = (c - a) / 2.0;
    k2 = (c - 2.0*b + a) / 2.0;
    k3 = (e - 3.0*c + 3.0*b - a) / 6.0;
    return 16.0 * (k0 + k1*d + k2*d*d + k3*d*d*d);
  endfunction

  task automatic modelReset();
    idx = 0; nextT2 = 2;
    expQ.delete(); cycQ.delete(); tolQ.delete(); tagQ.delete();
  endtask

  task automatic send(input int v);
    @(negedge clk);
    inValid = 1'b1;
    inData  = IN_W'(v);
    hist[idx] = v;
    if (idx >= 3 && (nextT2 >> 1) == idx - 2) begin
      expQ.push_back(interp(idx - 2, (nextT2 % 2 == 1) ? 0.5 : 0.0));
      cycQ.push_back(cyc + 5);
      tolQ.push_back(curTol);
      tagQ.push_back(curTag);
      nextT2 += 3;
    end
    idx++;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0;
    modelReset();
    idle(2);
    @(negedge clk);
    rst = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && outValid) begin
      seen++;
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected output", $sformatf("%0d", outData), "none");
      end else begin
        real e, diff; int c; real t; string tg;
        e = expQ.pop_front(); c = cycQ.pop_front(); t = tolQ.pop_front(); tg = tagQ.pop_front();
        diff = real'(outData) - e;
        if (diff < 0.0) diff = -diff;
        check(diff <= t, tg, $sformatf("%0d", outData), $sformatf("%f", e));
        check(cyc == c, "R5 latency", $sformatf("cycle %0d", cyc), $sformatf("cycle %0d", c));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    idle(3);
    check(outValid == 1'b0, "R9 reset state", $sformatf("%0b", outValid), "0");
    @(negedge clk);
    rst = 1'b0;

    // R1: three samples give nothing, the fourth gives one output
    curTag = "R1/R6 constant"; curTol = 0.01;
    for (int i = 0; i < 3; i++) send(1000);
    idle(10);
    check(seen == 0, "R1 early output", $sformatf("%0d", seen), "0");
    send(1000);
    idle(8);
    check(seen == 1, "R1 first output", $sformatf("%0d", seen), "1");

    // R6: extremes of the input range
    curTag = "R6 max";
    for (int i = 0; i < 12; i++) send(32767);
    idle(6);
    doReset();
    curTag = "R6 min";
    seen = 0;
    for (int i = 0; i < 12; i++) send(-32768);
    idle(6);
    // R2: 9 samples with full window from 4th on: positions 1,2.5,4,5.5,7,8.5 -> 6 outputs
    check(seen == 6, "R2 output count", $sformatf("%0d", seen), "6");
    check(expQ.size() == 0, "R2 pending", $sformatf("%0d", expQ.size()), "0");

    // R7: falling and rising ramps
    doReset();
    curTag = "R7 ramp down";
    for (int i = 0; i < 60; i++) send(10000 - 400*i);
    idle(6);
    doReset();
    curTag = "R7 ramp up";
    for (int i = 0; i < 60; i++) send(-20000 + 777*i);
    idle(6);

    // R3/R8: random full-scale samples with idle gaps
    doReset();
    curTag = "R3/R8 random"; curTol = 1.0;
    for (int i = 0; i < 1500; i++) begin
      send(int'($urandom_range(65535)) - 32768);
      if ($urandom_range(3) == 0) idle(1 + int'($urandom_range(2)));
    end
    idle(6);
    check(expQ.size() == 0, "R2 pending after random", $sformatf("%0d", expQ.size()), "0");

    // R9: reset in the middle of a burst, then a fresh sequence
    curTag = "R9 after reset";
    for (int i = 0; i < 50; i++) send(int'($urandom_range(65535)) - 32768);
    doReset();
    seen = 0;
    idle(8);
    check(seen == 0, "R9 flushed", $sformatf("%0d", seen), "0");
    for (int i = 0; i < 300; i++) send(int'($urandom_range(65535)) - 32768);
    idle(6);
    // 297 full-window arrivals -> ceil(2*297/3) = 198 outputs
    check(seen == 198, "R9/R2 restart count", $sformatf("%0d", seen), "198");
    check(expQ.size() == 0, "R9 pending", $sformatf("%0d", expQ.size()), "0");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule